// File: doc/BRIEF.md
# Battery-Backed Static RAM with Supply Supervision

This block is a clock-synchronous model of a 2K x 8 static RAM that keeps its contents on a backup battery. The array is reached through chip-select, write-enable and output-enable controls. A registered data output is qualified by an output-valid flag, and it reads zero whenever that flag is low, which stands for a high-impedance bus. Three comparator results arrive as synchronous digital inputs:
- the supply has dropped below the fail threshold;
- the supply is above the switch-over level;
- the battery is weak.

While the supply has failed, the block deselects itself. Every control, address and data input is then ignored, no location can change, and the output bus floats. When the supply comes back above switch-over, the array is moved to external power and a status bit shows this. At that power-up moment the weak-battery input is captured into a battery-bad flag. The flag can be read on its own output. While it is set, it swallows the next write that would otherwise land, and then it clears itself. Software uses this to detect that the battery contents may be stale.

A synchronous reset stands for fitting a fresh battery. It clears the flag and the source status, but it leaves the array contents alone.

Top module: `bbsram_top`

## Requirements
- R1: With `sup_fail` low and `bat_bad` low, a clock edge that sees `cs` and `we` both high stores `din` at `addr`.
- R2: A clock edge that sees `cs` and `oe` high, `we` low and `sup_fail` low makes `dout_vld` high on the next cycle, with `dout` equal to the stored byte. In every other case `dout_vld` is low and `dout` reads 0.
- R3: Write-enable wins over output-enable. An edge with `cs`, `we` and `oe` all high performs the write, and `dout_vld` stays low on the next cycle.
- R4: While `sup_fail` is high, no write request changes any location, whatever the controls, address or data are.
- R5: While `sup_fail` is high, `dout_vld` is low and `dout` is 0 in that same cycle, even if a read was issued on the previous edge.
- R6: `on_ext` equals the value `sup_supply_ok` had on the previous clock edge. A 1 means external supply and a 0 means battery.
- R7: A power-up event is an edge where `sup_supply_ok` is high and `on_ext` is low. At that edge `bat_low` is copied into `bat_bad`, and the new value is visible after the edge.
- R8: While `bat_bad` is high, the first edge with `cs` and `we` high and `sup_fail` low writes nothing. Reads, writes with `cs` low, and write attempts during supply failure leave `bat_bad` set.
- R9: The blocked write of R8 clears `bat_bad`, and later writes land normally.
- R10: Array contents survive any number of supply-fail and recovery sequences, with the battery either good or weak.
- R11: `rst` clears `bat_bad` and `on_ext` and leaves every array location unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (battery installation) |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | Write enable, active high |
| oe | input | 1 | Output enable, active high |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not valid |
| dout_vld | output | 1 | Read data valid (low means bus floated) |
| sup_fail | input | 1 | Supply below fail threshold |
| sup_supply_ok | input | 1 | Supply above switch-over level |
| bat_low | input | 1 | Battery voltage low |
| on_ext | output | 1 | Array powered from external supply |
| bat_bad | output | 1 | Battery-not-OK flag |

## Verification
Every address is written with an arithmetic pattern and read back. A second pattern then rewrites the whole array, so that a stuck or aliased address line is exposed. After that the full array is read back after each power cycle: once with the battery good, once with it weak, and once after a reset. This separates true retention from accidental rewriting. Three other input patterns are tried:
- writes and reads issued during supply failure, including a failure in the cycle a read result appears, which show the write protection and the immediate bus release;
- combined write-enable and output-enable, which shows the priority;
- reads and deselected writes issued while the battery flag is set, which show that only a real write attempt consumes the flag and that exactly one write is lost.

// File: rtl/bbsram_pkg.sv
package bbsram_pkg;

    // Decoded request presented by the control inputs on one clock edge.
    typedef struct packed {
        logic wr;
        logic rd;
    } bbsram_req_t;

    // Power source currently feeding the array.
    typedef enum logic {
        SRC_BAT = 1'b0,
        SRC_EXT = 1'b1
    } bbsram_src_t;

    // Decode the control pins. A failed supply deselects everything, and
    // write-enable masks output-enable.
    function automatic bbsram_req_t bbsram_decode(
        input logic cs,
        input logic we,
        input logic oe,
        input logic fail
    );
        bbsram_req_t r;
        r.wr = cs & we & ~fail;
        r.rd = cs & oe & ~we & ~fail;
        return r;
    endfunction

endpackage

// File: rtl/bbsram_supervisor.sv
module bbsram_supervisor
    import bbsram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sup_supply_ok,
    input  logic bat_low,
    input  logic wr_try,
    output logic on_ext,
    output logic bat_bad
);

    bbsram_src_t src_q;
    logic        flag_q;
    logic        pwr_up;

    assign on_ext  = (src_q == SRC_EXT);
    assign bat_bad = flag_q;
    assign pwr_up  = sup_supply_ok & ~on_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= SRC_BAT;
            flag_q <= 1'b0;
        end else begin
            src_q <= sup_supply_ok ? SRC_EXT : SRC_BAT;
            if (pwr_up)
                flag_q <= bat_low;
            else if (wr_try)
                flag_q <= 1'b0;
        end
    end

    // R6
    src_follow_chk: assert property (@(posedge clk) disable iff (rst)
        sup_supply_ok |=> on_ext);

    // R7
    flag_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (sup_supply_ok && !on_ext) |=> (bat_bad == $past(bat_low)));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bat_bad && wr_try && !(sup_supply_ok && !on_ext)) |=> !bat_bad);

endmodule

// File: rtl/bbsram_wr_gate.sv
module bbsram_wr_gate
    import bbsram_pkg::*;
(
    input  bbsram_req_t req,
    input  logic        bat_bad,
    output logic        wr_try,
    output logic        wr_en
);

    // A qualified write attempt always consumes the flag; it only reaches
    // the array when the flag is clear.
    always_comb begin
        wr_try = req.wr;
        wr_en  = req.wr & ~bat_bad;
    end

endmodule

// File: rtl/bbsram_array.sv
module bbsram_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              fail,
    input  logic              blk_flag,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] q;
    logic              rd_q;

    // Storage is battery backed: never reset.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[addr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            q    <= '0;
        end else begin
            rd_q <= rd_en;
            q    <= mem[addr];
        end
    end

    assign dout_vld = rd_q & ~fail;
    assign dout     = dout_vld ? q : '0;

    // R4
    fail_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> !wr_en);

    // R8
    flag_block_chk: assert property (@(posedge clk) disable iff (rst)
        blk_flag |-> !wr_en);

    // R5
    fail_float_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> (dout == '0));

endmodule

// File: rtl/bbsram_top.sv
module bbsram_top
    import bbsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    input  logic              sup_fail,
    input  logic              sup_supply_ok,
    input  logic              bat_low,
    output logic              on_ext,
    output logic              bat_bad
);

    bbsram_req_t req;
    logic        wr_try;
    logic        wr_en;

    assign req = bbsram_decode(cs, we, oe, sup_fail);

    bbsram_supervisor i_sup (
        .clk          (clk),
        .rst          (rst),
        .sup_supply_ok(sup_supply_ok),
        .bat_low      (bat_low),
        .wr_try       (wr_try),
        .on_ext       (on_ext),
        .bat_bad      (bat_bad)
    );

    bbsram_wr_gate i_gate (
        .req    (req),
        .bat_bad(bat_bad),
        .wr_try (wr_try),
        .wr_en  (wr_en)
    );

    bbsram_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_arr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (req.rd),
        .fail    (sup_fail),
        .blk_flag(bat_bad),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_vld(dout_vld)
    );

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> $past(req.rd));

    // R3
    wr_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && we && oe) |=> !dout_vld);

endmodule

// File: tb/test_bbsram_top.sv
module test_bbsram_top;

    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b0;
    logic          cs = 1'b0, we = 1'b0, oe = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_vld;
    logic          sup_fail = 1'b0, sup_supply_ok = 1'b1, bat_low = 1'b0;
    logic          on_ext, bat_bad;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    bbsram_top i_bbsram_top (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .oe(oe),
        .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld),
        .sup_fail(sup_fail), .sup_supply_ok(sup_supply_ok), .bat_low(bat_low),
        .on_ext(on_ext), .bat_bad(bat_bad)
    );

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 37 + k * 91 + (a >> 8) * 5) & 8'hFF);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        cs = 1; we = 1; oe = 0; addr = AW'(a); din = d;
        @(negedge clk);
        cs = 0; we = 0;
    endtask

    task automatic rd_chk(input int a, input string tag);
        @(negedge clk);
        cs = 1; oe = 1; we = 0; addr = AW'(a);
        @(negedge clk);
        chk(dout_vld === 1'b1 && dout === model[a], tag, {dout_vld, dout}, {1'b1, model[a]});
        cs = 0; oe = 0;
    endtask

    task automatic sweep_read(input string tag);
        for (int a = 0; a < DEPTH; a++) rd_chk(a, tag);
    endtask

    task automatic power_fail;
        @(negedge clk);
        sup_fail = 1; sup_supply_ok = 0;
        @(negedge clk);
        chk(on_ext === 1'b0, "R6 on battery", on_ext, 0);
    endtask

    task automatic recover(input logic bl);
        @(negedge clk);
        sup_fail = 0; sup_supply_ok = 1; bat_low = bl;
        @(negedge clk);
        chk(bat_bad === bl, "R7 flag sampled", bat_bad, bl);
        chk(on_ext === 1'b1, "R6 on external", on_ext, 1);
        bat_low = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk);
        chk(bat_bad === 1'b0 && on_ext === 1'b0, "R11 reset state", {bat_bad, on_ext}, 0);
        chk(dout_vld === 1'b0 && dout === '0, "R2 idle output", {dout_vld, dout}, 0);
        rst = 0;
        @(negedge clk);
        chk(bat_bad === 1'b0 && on_ext === 1'b1, "R7 first power-up good battery", {bat_bad, on_ext}, 1);

        // R1 / R2: two full-array patterns
        for (int k = 0; k < 2; k++) begin
            for (int a = 0; a < DEPTH; a++) begin
                model[a] = pat(a, k);
                wr(a, model[a]);
            end
            sweep_read("R1 sweep");
        end

        // R2: output-enable without chip select gives no data
        @(negedge clk); cs = 0; oe = 1; addr = 11'd3;
        @(negedge clk);
        chk(dout_vld === 1'b0 && dout === '0, "R2 no cs", {dout_vld, dout}, 0);
        oe = 0;

        // R3: write-enable beats output-enable
        @(negedge clk); cs = 1; we = 1; oe = 1; addr = 11'd100; din = 8'hA5;
        @(negedge clk);
        chk(dout_vld === 1'b0, "R3 priority", dout_vld, 0);
        cs = 0; we = 0; oe = 0;
        model[100] = 8'hA5;
        rd_chk(100, "R3 write landed");

        // R5: failure in the cycle a read result appears
        @(negedge clk); cs = 1; oe = 1; addr = 11'd7;
        @(negedge clk);
        cs = 0; oe = 0;
        chk(dout_vld === 1'b1, "R2 read before fail", dout_vld, 1);
        sup_fail = 1;
        #1;
        chk(dout_vld === 1'b0 && dout === '0, "R5 immediate float", {dout_vld, dout}, 0);
        sup_fail = 0;

        // R4 / R5: full supply failure, attempts ignored
        power_fail();
        for (int a = 0; a < 8; a++) wr(a * 250, ~model[a * 250]);
        @(negedge clk); cs = 1; oe = 1; addr = 11'd0;
        @(negedge clk);
        chk(dout_vld === 1'b0 && dout === '0, "R5 read during fail", {dout_vld, dout}, 0);
        cs = 0; oe = 0;
        recover(1'b0);
        for (int a = 0; a < 8; a++) rd_chk(a * 250, "R4 no write during fail");
        sweep_read("R10 retain good battery");

        // R8 / R9: weak battery
        power_fail();
        wr(9, 8'h00);          // attempt during failure must not consume the flag
        recover(1'b1);
        rd_chk(9, "R8 read with flag");
        chk(bat_bad === 1'b1, "R8 read keeps flag", bat_bad, 1);
        @(negedge clk); cs = 0; we = 1; addr = 11'd9; din = 8'h11;
        @(negedge clk); we = 0;
        chk(bat_bad === 1'b1, "R8 deselected write keeps flag", bat_bad, 1);
        wr(9, 8'h5A);
        chk(bat_bad === 1'b0, "R9 flag cleared", bat_bad, 0);
        rd_chk(9, "R8 blocked write");
        model[9] = 8'h5A;
        wr(9, 8'h5A);
        rd_chk(9, "R9 next write lands");
        model[10] = 8'hC3;
        wr(10, 8'hC3);
        rd_chk(10, "R9 later write lands");
        sweep_read("R10 retain weak battery");

        // R11: reset clears flag, keeps contents
        power_fail();
        recover(1'b1);
        @(negedge clk); rst = 1;
        @(negedge clk);
        chk(bat_bad === 1'b0 && on_ext === 1'b0, "R11 reset clears", {bat_bad, on_ext}, 0);
        rst = 0;
        @(negedge clk);
        sweep_read("R11 contents kept");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule